// File: doc/BRIEF.md
# Serial Command Attenuation Controller

The block scales a stream of 16-bit signed audio samples by a gain chosen by a host controller. The host sends a 14-bit command over three wires: a bit clock, a data line and an active-low load strobe. The first eight bits of a command are a fixed signature. The last six bits are the attenuation code. When the signature matches, the code is kept and used for every later sample. When it does not match, the command is dropped.

All three host lines are asynchronous to the system clock. They are synchronised, and their edges are detected in the system clock domain. The code sets a Q1.15 gain coefficient:

- Code 0 is unity gain.
- Codes 1 to 62 fall linearly in amplitude. This gives a dB scale that is fine at the top and coarse at the bottom.
- Code 63 is full mute.

Each sample is multiplied by its coefficient, rounded and clamped to 16 bits, and delivered two cycles later. Reset returns the block to unity gain.

Top module: `serial_attenuator`

## Requirements
- R1: On each rising edge of the host clock, the data line is shifted in. The command is sent least significant bit first: the first 8 bits are the signature, and the next 6 bits are the code, lowest code bit first. A falling edge of the load strobe commits the last 14 bits. The new code takes effect only when the signature equals 0x5D. This means the first bit sent is 1, and the byte 0xBA sent in that bit order does not match.
- R2: A commit whose signature differs from 0x5D leaves the current code, and so the output gain, unchanged.
- R3: Two cases leave the gain unchanged:
  - the host lines at rest (clock high, load high), with the data line toggling;
  - clock pulses with load held high.
- R4: While rst_ni is low, smp_valid_o and smp_data_o are 0. After reset, the code is 0 and each output equals its input sample.
- R5: The coefficient g in Q1.15 depends on the code c:
  - c = 0 gives g = 32768 (1.0);
  - 1 ≤ c ≤ 62 gives g = (63 − c)·512, so code 31 is −6.02 dB and code 62 is −36.12 dB;
  - c = 63 gives g = 0, which is mute.
- R6: Each output is floor((x·g + 16384) / 32768), clamped to the range −32768..32767. Halves round upward.
- R7: One output is produced for each input sample, with smp_valid_o high exactly 2 clock cycles after smp_valid_i.
- R8: The gain changes only between samples, and an output never mixes two gains. Take the falling edge of the load pin as the reference point:
  - samples accepted on the first three system clock edges after it use the old gain;
  - samples accepted from the fourth edge on use the new gain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hclk_i | input | 1 | Host command bit clock, idles high |
| hdata_i | input | 1 | Host command data, sampled on hclk_i rising |
| hload_ni | input | 1 | Host commit strobe, active low, commits on falling edge |
| smp_valid_i | input | 1 | Input sample valid |
| smp_data_i | input | 16 | Input sample, two's complement |
| smp_valid_o | output | 1 | Output sample valid |
| smp_data_o | output | 16 | Scaled sample, two's complement |

## Verification
The timing of each result is as follows:
- A scaled sample appears two system cycles after it is accepted. The scoreboard stamps every expected item with that due cycle, and the monitor rejects any output that arrives in another cycle.
- A host line change passes through two synchroniser flops and one edge flop before it can affect the code. The gain test therefore holds each host level for four system cycles, and sends samples only after the commit has settled.
- To check R8, the bench lowers the load pin while it streams samples on every cycle. It expects the old gain for the three samples accepted on the first three edges, and the new gain from the fourth edge on.

// File: rtl/attn_pkg.sv
`timescale 1ns/1ps
package attn_pkg;
  localparam int unsigned SMP_W   = 16;
  localparam int unsigned CODE_W  = 6;
  localparam int unsigned SIG_W   = 8;
  localparam int unsigned FRAC    = 15;
  localparam int unsigned COEF_W  = FRAC + 1;
  localparam int unsigned SYNC_N  = 2;
  localparam logic [SIG_W-1:0] SIG_VAL = 8'h5D;

  typedef logic [CODE_W-1:0] code_t;
  typedef logic [COEF_W-1:0] coef_t;
endpackage

// File: rtl/attn_host_rx.sv
`timescale 1ns/1ps
module attn_host_rx #(
  parameter int unsigned SYNC_N = 2,
  parameter int unsigned SIG_W  = 8,
  parameter int unsigned CODE_W = 6,
  parameter logic [SIG_W-1:0] SIG_VAL = 8'h5D
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hclk_i,
  input  logic              hdata_i,
  input  logic              hload_ni,
  output logic [CODE_W-1:0] code_o
);
  localparam int unsigned CMD_W = SIG_W + CODE_W;
  // idle levels: load high, data low, clock high
  localparam logic [2:0] IDLE = 3'b101;

  logic [2:0] pin_w;
  logic [2:0] syn_w;
  assign pin_w = {hload_ni, hdata_i, hclk_i};

  for (genvar k = 0; k < 3; k++) begin : g_sync
    logic [SYNC_N-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= {SYNC_N{IDLE[k]}};
      else         chain_q <= {chain_q[SYNC_N-2:0], pin_w[k]};
    end
    assign syn_w[k] = chain_q[SYNC_N-1];
  end

  logic hclk_d_q, hload_d_q;
  logic clk_rise_w, ld_fall_w, sig_ok_w;
  logic [CMD_W-1:0]  sr_q;
  logic [CODE_W-1:0] code_q;

  assign clk_rise_w = syn_w[0] & ~hclk_d_q;
  assign ld_fall_w  = ~syn_w[2] & hload_d_q;
  assign sig_ok_w   = (sr_q[SIG_W-1:0] == SIG_VAL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hclk_d_q  <= 1'b1;
      hload_d_q <= 1'b1;
      sr_q      <= '0;
      code_q    <= '0;
    end else begin
      hclk_d_q  <= syn_w[0];
      hload_d_q <= syn_w[2];
      // LSB first: newest bit enters at the top
      if (clk_rise_w) sr_q <= {syn_w[1], sr_q[CMD_W-1:1]};
      if (ld_fall_w && sig_ok_w) code_q <= sr_q[CMD_W-1:SIG_W];
    end
  end

  assign code_o = code_q;

  a_r1_sig_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_fall_w && sig_ok_w) |=> code_o == $past(sr_q[CMD_W-1:SIG_W]));
  a_r2_bad_sig_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_fall_w && !sig_ok_w) |=> $stable(code_o));
  a_r3_no_load_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_fall_w |=> $stable(code_o));
endmodule

// File: rtl/attn_gain_map.sv
`timescale 1ns/1ps
module attn_gain_map #(
  parameter int unsigned CODE_W = 6,
  parameter int unsigned FRAC   = 15
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [FRAC:0]     coef_o
);
  localparam int unsigned COEF_W = FRAC + 1;
  localparam int unsigned SH     = FRAC - CODE_W;
  localparam int unsigned MAXC   = (1 << CODE_W) - 1;

  logic [COEF_W-1:0] diff_w;
  assign diff_w = COEF_W'(MAXC) - COEF_W'(code_i);

  // code 0 is unity; others step linearly down to zero at the top code
  always_comb begin
    if (code_i == '0) coef_o = COEF_W'(1) << FRAC;
    else              coef_o = diff_w << SH;
  end
endmodule

// File: rtl/attn_scaler.sv
`timescale 1ns/1ps
module attn_scaler #(
  parameter int unsigned SMP_W = 16,
  parameter int unsigned FRAC  = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [SMP_W-1:0] data_i,
  input  logic [FRAC:0]    coef_i,
  output logic             valid_o,
  output logic [SMP_W-1:0] data_o
);
  localparam int unsigned COEF_W = FRAC + 1;
  localparam int unsigned PW     = SMP_W + COEF_W + 1;
  localparam logic signed [PW-1:0] HALF = signed'(PW'(1) << (FRAC - 1));
  localparam logic signed [PW-1:0] MAXV = signed'((PW'(1) << (SMP_W - 1)) - PW'(1));
  localparam logic signed [PW-1:0] MINV = -MAXV - signed'(PW'(1));
  localparam logic [COEF_W-1:0] UNITY = COEF_W'(1) << FRAC;

  logic              v1_q, v2_q;
  logic [SMP_W-1:0]  x1_q, y2_q;
  logic [COEF_W-1:0] g1_q;
  logic signed [PW-1:0] prod_w, rnd_w, shr_w;
  logic [SMP_W-1:0]  sat_w;

  assign prod_w = $signed({{(PW-SMP_W){x1_q[SMP_W-1]}}, x1_q})
                * $signed({{(PW-COEF_W){1'b0}}, g1_q});
  assign rnd_w  = prod_w + HALF;
  assign shr_w  = rnd_w >>> FRAC;

  always_comb begin
    if (shr_w > MAXV)      sat_w = MAXV[SMP_W-1:0];
    else if (shr_w < MINV) sat_w = MINV[SMP_W-1:0];
    else                   sat_w = shr_w[SMP_W-1:0];
  end

  // coefficient is captured with the sample: one gain per sample
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1_q <= 1'b0;
      x1_q <= '0;
      g1_q <= '0;
      v2_q <= 1'b0;
      y2_q <= '0;
    end else begin
      v1_q <= valid_i;
      if (valid_i) begin
        x1_q <= data_i;
        g1_q <= coef_i;
      end
      v2_q <= v1_q;
      if (v1_q) y2_q <= sat_w;
    end
  end

  assign valid_o = v2_q;
  assign data_o  = v2_q ? y2_q : '0;

  a_r7_two_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> ##1 valid_o);
  a_r5_mute_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v1_q && g1_q == '0) |=> data_o == '0);
  a_r4_unity_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v1_q && g1_q == UNITY) |=> data_o == $past(x1_q));
endmodule

// File: rtl/serial_attenuator.sv
`timescale 1ns/1ps
module serial_attenuator
  import attn_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hclk_i,
  input  logic             hdata_i,
  input  logic             hload_ni,
  input  logic             smp_valid_i,
  input  logic [SMP_W-1:0] smp_data_i,
  output logic             smp_valid_o,
  output logic [SMP_W-1:0] smp_data_o
);
  code_t code_w;
  coef_t coef_w;

  attn_host_rx #(
    .SYNC_N (SYNC_N),
    .SIG_W  (SIG_W),
    .CODE_W (CODE_W),
    .SIG_VAL(SIG_VAL)
  ) u_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hclk_i  (hclk_i),
    .hdata_i (hdata_i),
    .hload_ni(hload_ni),
    .code_o  (code_w)
  );

  attn_gain_map #(
    .CODE_W(CODE_W),
    .FRAC  (FRAC)
  ) u_map (
    .code_i(code_w),
    .coef_o(coef_w)
  );

  attn_scaler #(
    .SMP_W(SMP_W),
    .FRAC (FRAC)
  ) u_scl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(smp_valid_i),
    .data_i (smp_data_i),
    .coef_i (coef_w),
    .valid_o(smp_valid_o),
    .data_o (smp_data_o)
  );
endmodule

// File: tb/sim_serial_attenuator.sv
`timescale 1ns/1ps
module sim_serial_attenuator;
  logic clk = 1'b0;
  logic rst_ni;
  logic hclk, hdata, hload_n;
  logic smp_valid_i;
  logic [15:0] smp_data_i;
  logic smp_valid_o;
  logic [15:0] smp_data_o;

  always #2.5 clk = ~clk;

  serial_attenuator u0 (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .hclk_i     (hclk),
    .hdata_i    (hdata),
    .hload_ni   (hload_n),
    .smp_valid_i(smp_valid_i),
    .smp_data_i (smp_data_i),
    .smp_valid_o(smp_valid_o),
    .smp_data_o (smp_data_o)
  );

  typedef struct {
    logic signed [15:0] v;
    int                 due;
    string              tag;
  } exp_t;

  exp_t q[$];
  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int cur_g = 32768;
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  function automatic int gmodel(input int c);
    if (c == 0) return 32768;
    return (63 - c) * 512;
  endfunction

  function automatic logic signed [15:0] scale(input int x, input int g);
    longint p;
    p = longint'(x) * longint'(g) + 64'sd16384;
    p = p >>> 15;
    if (p > 32767) p = 32767;
    if (p < -32768) p = -32768;
    return 16'(p);
  endfunction

  // monitor: pops the scoreboard as results appear
  always @(negedge clk) begin
    if (rst_ni && smp_valid_o) begin
      if (q.size() == 0) begin
        chk(1'b0, "R7 unexpected output", int'($signed(smp_data_o)), 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk($signed(smp_data_o) == e.v, e.tag, int'($signed(smp_data_o)), int'(e.v));
        chk(cyc == e.due, "R7 output cycle", cyc, e.due);
      end
    end
  end

  task automatic smp(input logic signed [15:0] x, input int g, input string tag);
    exp_t e;
    smp_valid_i = 1'b1;
    smp_data_i  = x;
    e.v   = scale(int'(x), g);
    e.due = cyc + 2;
    e.tag = tag;
    q.push_back(e);
    @(negedge clk);
    smp_valid_i = 1'b0;
  endtask

  task automatic host_bit(input bit b);
    hclk  = 1'b0;
    hdata = b;
    repeat (4) @(negedge clk);
    hclk = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic send_bits(input logic [7:0] sig, input logic [5:0] code);
    for (int i = 0; i < 14; i++) host_bit(i < 8 ? sig[i] : code[i-8]);
    hdata = 1'b0;
  endtask

  task automatic commit();
    hload_n = 1'b0;
    repeat (6) @(negedge clk);
    hload_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic drain();
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      chk(1'b0, "watchdog", cyc, 0);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0; hclk = 1'b1; hdata = 1'b0; hload_n = 1'b1;
    smp_valid_i = 1'b0; smp_data_i = '0;
    repeat (3) @(negedge clk);
    chk(smp_valid_o == 1'b0, "R4 valid in reset", int'(smp_valid_o), 0);
    chk(smp_data_o == 16'd0, "R4 data in reset", int'(smp_data_o), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);

    // unity after reset, full-scale boundaries
    smp(16'sd12345, 32768, "R4 unity after reset");
    smp(-16'sd32768, 32768, "R6 min boundary");
    smp(16'sd32767, 32768, "R6 max boundary");
    smp(-16'sd1, 32768, "R6 minus one");
    drain();

    send_bits(8'h5D, 6'd1); commit(); cur_g = gmodel(1);
    smp(16'sd32767, cur_g, "R1 code 1 loaded");
    smp(-16'sd20000, cur_g, "R5 code 1");
    drain();

    send_bits(8'h5D, 6'd31); commit(); cur_g = gmodel(31);
    smp(16'sd1001, cur_g, "R6 half gain");
    smp(-16'sd3, cur_g, "R6 round negative");
    smp(16'sd3, cur_g, "R6 round half up");
    drain();

    send_bits(8'h5C, 6'd5); commit();
    smp(16'sd1001, cur_g, "R2 bad signature ignored");
    send_bits(8'hBA, 6'd5); commit();
    smp(16'sd1001, cur_g, "R1 msb-first signature ignored");
    drain();

    for (int i = 0; i < 10; i++) begin
      hdata = ~hdata;
      repeat (3) @(negedge clk);
    end
    hdata = 1'b0;
    smp(16'sd4000, cur_g, "R3 idle lines");
    send_bits(8'h5D, 6'd7);
    repeat (6) @(negedge clk);
    smp(16'sd4000, cur_g, "R3 clocks without load");
    drain();
    commit(); cur_g = gmodel(7);
    smp(16'sd4000, cur_g, "R1 code 7 after late load");
    drain();

    send_bits(8'h5D, 6'd62); commit(); cur_g = gmodel(62);
    smp(16'sd32767, cur_g, "R5 code 62");
    drain();
    send_bits(8'h5D, 6'd63); commit(); cur_g = gmodel(63);
    smp(16'sd32767, cur_g, "R5 mute positive");
    smp(-16'sd32768, cur_g, "R5 mute negative");
    drain();

    // switch mute -> unity while streaming
    send_bits(8'h5D, 6'd0);
    hload_n = 1'b0;
    smp(16'sd1000, 0, "R8 edge1 old gain");
    smp(16'sd1001, 0, "R8 edge2 old gain");
    smp(16'sd1002, 0, "R8 edge3 old gain");
    smp(16'sd1003, 32768, "R8 edge4 new gain");
    smp(16'sd1004, 32768, "R8 edge5 new gain");
    repeat (3) @(negedge clk);
    hload_n = 1'b1;
    cur_g = 32768;
    drain();

    send_bits(8'h5D, 6'd20); commit();
    drain();
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    chk(smp_valid_o == 1'b0, "R4 valid in mid reset", int'(smp_valid_o), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    cur_g = 32768;
    smp(-16'sd7777, cur_g, "R4 unity after mid reset");
    drain();

    chk(q.size() == 0, "R7 outputs outstanding", q.size(), 0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule